// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor

This block is a purely combinational N-bit integer adder-subtractor for two's complement operands. A single operation select decides whether the second operand is added to the first or subtracted from it. Both operations share one ripple-carry chain. For subtraction, every bit of the second operand is inverted and a carry of one is injected into the lowest stage. The result is therefore first + (inverted second) + 1, which equals first minus second modulo 2^N.

Each stage of the chain is a full adder made of two half adders and an OR gate. The carry travels from the least significant stage to the most significant stage. The block reports three things:
- the N-bit result;
- the raw carry out of the top stage;
- a signed overflow flag, formed by comparing the carry entering the sign stage with the carry leaving it.

With the default width of four, the representable range is -8 to +7, and zero has one encoding.

Top module: `adsub_core`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `op_sel` = 1 (subtract), `result` equals (`op_a` - `op_b`) modulo 2^WIDTH, computed as `op_a` + ~`op_b` + 1.
- R3: `overflow` is 1 exactly when the mathematically exact signed result lies outside -2^(WIDTH-1) to 2^(WIDTH-1)-1. Operands are read as two's complement, with bit WIDTH-1 as the sign.
- R4: `carry_out` is the raw carry leaving the top stage. When adding, it is 1 iff the unsigned sum reaches 2^WIDTH. When subtracting, it is 1 iff `op_a` >= `op_b` as unsigned values, meaning no borrow.
- R5: For WIDTH=4 the following hold:
  - 5+3 gives 1000 with overflow.
  - (-7)+(-2) gives 0111 with overflow.
  - 5+2 gives 0111 without overflow.
  - (-3)+(-5) gives 1000 without overflow.
- R6: Subtracting the most negative value from zero (0 - (-8) for WIDTH=4) gives 1000 and raises `overflow`.
- R7: The outputs depend only on the present inputs. There is no state, and all-zero inputs give `result`=0, `carry_out`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| op_sel | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Raw carry from the top stage |
| overflow | output | 1 | Signed overflow flag |

## Verification
The immediate assertions inside the top module assume that the operand and select inputs are settled two-state values whenever the combinational logic is evaluated. The bench applies each input vector at a clock edge and samples half a period later, so that no assertion or check sees a partly updated set of inputs. The stimulus sweeps every pair of operands under both operations at the default width, so no input combination is left outside what the assertions cover. The named sign-boundary cases are then repeated as explicit checks.

// File: rtl/adsub_pkg.sv
package adsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } adsub_op_e;
endpackage

// File: rtl/adsub_half_adder.sv
module adsub_half_adder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  always_comb begin
    s = x ^ y;
    c = x & y;
  end
endmodule

// File: rtl/adsub_full_adder.sv
module adsub_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p_s, p_c, q_c;

  // first half adder: propagate and generate of the operand pair
  adsub_half_adder u_ha0 (.x(a),   .y(b),  .s(p_s), .c(p_c));
  // second half adder: fold in the incoming carry
  adsub_half_adder u_ha1 (.x(p_s), .y(ci), .s(s),   .c(q_c));

  always_comb co = p_c | q_c;
endmodule

// File: rtl/adsub_b_select.sv
module adsub_b_select #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             invert,
  output logic [WIDTH-1:0] b_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // per-bit 2:1 choice between true and inverted operand bit
    always_comb b_out[i] = invert ? ~b_in[i] : b_in[i];
  end
endmodule

// File: rtl/adsub_ripple_chain.sv
module adsub_ripple_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  output logic [WIDTH-1:0] s,
  output logic [WIDTH:0]   c
);
  always_comb c[0] = c_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    adsub_full_adder u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(c[i]),
      .s (s[i]),
      .co(c[i+1])
    );
  end
endmodule

// File: rtl/adsub_core.sv
module adsub_core #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);
  import adsub_pkg::*;

  localparam int MSB = WIDTH - 1;

  adsub_op_e        op;
  logic             inject;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carries;

  always_comb begin
    op     = adsub_op_e'(op_sel);
    inject = (op == OP_SUB);
  end

  adsub_b_select #(.WIDTH(WIDTH)) u_bsel (
    .b_in  (op_b),
    .invert(inject),
    .b_out (b_eff)
  );

  adsub_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a   (op_a),
    .b   (b_eff),
    .c_in(inject),
    .s   (result),
    .c   (carries)
  );

  always_comb begin
    carry_out = carries[WIDTH];
    // signed overflow: carry into the sign stage differs from carry out of it
    overflow  = carries[WIDTH] ^ carries[MSB];
  end

  // The checks below compare the ripple chain against independent arithmetic.
  always_comb begin
    // R3: the sign rule must agree with the carry-comparison flag
    a_r3_sign_rule: assert (overflow ==
      ((op_a[MSB] == b_eff[MSB]) && (result[MSB] != op_a[MSB])))
      else $error("R3 overflow disagrees with sign rule");
    if (op_sel == 1'b0) begin
      // R1 and R4: the carry and the sum together form the unsigned total
      a_r1_add_value: assert ({carry_out, result} ==
        ({1'b0, op_a} + {1'b0, op_b}))
        else $error("R1 add total mismatch");
    end else begin
      a_r2_sub_value: assert (result == WIDTH'(op_a - op_b))
        else $error("R2 difference mismatch");
      a_r4_no_borrow: assert (carry_out == (op_a >= op_b))
        else $error("R4 borrow flag mismatch");
    end
    if ((op_sel == 1'b1) && (op_a == op_b)) begin
      a_r2_self_sub: assert ((result == '0) && carry_out && !overflow)
        else $error("R2 self subtraction not zero");
    end
  end
endmodule

// File: tb/tb_adsub_core.sv
module tb_adsub_core;
  localparam int WIDTH = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MOD = 1 << WIDTH;
  localparam int HALF = 1 << (WIDTH - 1);

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] op_a, op_b;
  logic             op_sel;
  logic [WIDTH-1:0] result;
  logic             carry_out, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  adsub_core #(.WIDTH(WIDTH)) dut (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(result), .carry_out(carry_out), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sval(input int v);
    return (v >= HALF) ? v - MOD : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit s);
    @(posedge clk);
    op_a = WIDTH'(a); op_b = WIDTH'(b); op_sel = s;
    @(negedge clk);
  endtask

  initial begin
    op_a = '0; op_b = '0; op_sel = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: quiet outputs for all-zero inputs
    chk("R7 result", int'(result), 0);
    chk("R7 carry", int'(carry_out), 0);
    chk("R7 overflow", int'(overflow), 0);

    // exhaustive sweep: R1 R2 R3 R4
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < MOD; a++) begin
        for (int b = 0; b < MOD; b++) begin
          int exact, exp_res, exp_c, exp_v;
          apply(a, b, s[0]);
          exact   = (s == 0) ? sval(a) + sval(b) : sval(a) - sval(b);
          exp_res = ((exact % MOD) + MOD) % MOD;
          exp_v   = (exact > HALF - 1 || exact < -HALF) ? 1 : 0;
          exp_c   = (s == 0) ? (((a + b) >= MOD) ? 1 : 0) : ((a >= b) ? 1 : 0);
          chk((s == 0) ? "R1 sum" : "R2 difference", int'(result), exp_res);
          chk("R3 overflow", int'(overflow), exp_v);
          chk("R4 carry", int'(carry_out), exp_c);
        end
      end
    end

    // R5: named sign-boundary examples
    apply(5, 3, 1'b0);
    chk("R5 5+3 result", int'(result), 8);  chk("R5 5+3 ovf", int'(overflow), 1);
    apply(9, 14, 1'b0);
    chk("R5 -7+-2 result", int'(result), 7); chk("R5 -7+-2 ovf", int'(overflow), 1);
    apply(5, 2, 1'b0);
    chk("R5 5+2 result", int'(result), 7);  chk("R5 5+2 ovf", int'(overflow), 0);
    apply(13, 11, 1'b0);
    chk("R5 -3+-5 result", int'(result), 8); chk("R5 -3+-5 ovf", int'(overflow), 0);
    // R6: zero minus most negative
    apply(0, 8, 1'b1);
    chk("R6 result", int'(result), 8);
    chk("R6 overflow", int'(overflow), 1);
    chk("R6 carry", int'(carry_out), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule